// File: doc/BRIEF.md
# Descriptor-Chained Quad SPI Sequencer

This block runs a serial-flash style transfer as a chain of segments. Each segment is one 32-bit descriptor held in a small on-block table. A segment is transmit-only, receive-only or dummy clocks, and it runs on one, two or four data lanes. A start pulse begins at the entry index presented on `firstIdx`. The engine then follows each descriptor's next-index field until it finishes a segment marked final, and raises a sticky done flag. A descriptor that cannot be executed raises a sticky programming-error flag instead.

Transmit bytes come from an external FIFO through a pop strobe. Received bytes leave through a push strobe. The pin side is a one-clock-per-cycle serializer interface: `sclkPulse` marks a cycle in which one serial clock is issued. `sioOut` and `sioOe` give the driven lane values, and `sioIn` is sampled in that same cycle. Clock division and chip-select setup and hold delays belong to the pin stage and are not part of this block.

Descriptor layout (bit fields):
- [1:0] lane mode: 00 single, 01 dual, 1x quad.
- [3:2] transmit mode: 00 transmit disabled, with the lines released; 01 transmit from the FIFO; 1x illegal.
- [6] receive enable.
- [8] close: release chip select after this segment.
- [9] final segment.
- [11:10] count unit: 00 bits, 01 one byte, 10 four bytes, 11 sixteen bytes.
- [15:12] next index.
- [30:16] unit count.

Top module: `qspi_chain_seq`

## Requirements
- R1: Out of reset `busy`, `doneFlag`, `progErr` and `csActive` are 0, and no clock, pop or push is issued while `busy` is 0.
- R2: A transmit segment (mode 01, receive 0) in single-lane mode shifts each byte MSB first on `sioOut[0]`, one bit per `sclkPulse`. `txPop` is high in the first clock of each byte, and `sioOe` is 0001 for the whole segment.
- R3: Dual lane mode sends two bits per clock on `sioOut[1:0]`, with bit 1 carrying the higher bit and `sioOe` = 0011. Quad mode sends four bits per clock on `sioOut[3:0]`, with `sioOe` = 1111.
- R4: A receive segment (bit 6 set, mode 00) leaves `sioOe` at 0. It shifts in MSB first from `sioIn[1]` (single), `sioIn[1:0]` (dual) or `sioIn[3:0]` (quad). It pulses `rxPush` in the clock that completes each byte, with the assembled byte on `rxData`.
- R5: Byte units of 1, 4 and 16 give a segment of count × unit × 8 / lanes clocks.
- R6: A segment with transmit disabled and receive off issues dummy clocks with `sioOe` = 0 and no pop or push. In bit units it issues floor(count / lanes) clocks.
- R7: A start pulse while idle begins at `firstIdx` and follows the next-index fields, with `curIdx` showing the executing descriptor. There is one idle cycle between segments. `doneFlag` sets on the clock edge that ends the final segment's last clock, and `busy` falls at the same edge.
- R8: At a byte boundary of a transmit segment, no clock is issued while `txEmpty` is 1.
- R9: At a byte boundary of a receive segment, no clock is issued while `rxFull` is 1.
- R10: Starting on an illegal descriptor sets `progErr` and issues no clock, and `csActive` keeps its value. Illegal means any of: transmit mode 1x; transmit together with receive; bit units with transmit or receive; a computed clock count of 0.
- R11: An illegal descriptor reached through a next index sets `progErr`, ends the chain without `doneFlag`, and drops `csActive`.
- R12: `csActive` rises when a segment is loaded. It falls after the last clock of a segment with the close bit set, and otherwise stays high after the chain ends.
- R13: `doneFlag` (`statusClr[0]`) and `progErr` (`statusClr[1]`) stay set until a 1 is written to their clear bit. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| descWe | input | 1 | Descriptor table write strobe |
| descAddr | input | 4 | Descriptor table write index |
| descData | input | 32 | Descriptor word to write |
| firstIdx | input | 4 | Index of the first descriptor |
| start | input | 1 | Start pulse |
| statusClr | input | 2 | Write-1-to-clear: bit 0 done, bit 1 error |
| txData | input | 8 | Head byte of the transmit FIFO |
| txEmpty | input | 1 | Transmit FIFO empty |
| txPop | output | 1 | Consume the head transmit byte |
| rxData | output | 8 | Received byte |
| rxFull | input | 1 | Receive FIFO full |
| rxPush | output | 1 | Write `rxData` to the receive FIFO |
| sclkPulse | output | 1 | One serial clock this cycle |
| sioOut | output | 4 | Lane output values |
| sioOe | output | 4 | Lane output enables |
| sioIn | input | 4 | Lane input values |
| csActive | output | 1 | Chip select asserted |
| busy | output | 1 | Chain in progress |
| doneFlag | output | 1 | Sticky chain-done flag |
| progErr | output | 1 | Sticky programming-error flag |
| curIdx | output | 4 | Current descriptor index |

## Verification
The checks on pops and clocks assume that the FIFO flags describe the FIFO that the block actually drains and fills. `txEmpty` is not asserted while `txPop` is being honoured, and the descriptor table is written only while the engine is idle. The stimulus meets these assumptions by writing descriptors only between chains and by changing the FIFO flags and lane inputs only away from the clock edge. Receive backpressure is not asserted as a property, because the bench toggles `rxFull` at random in the middle of a byte. That behaviour is checked only against the reference model.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  localparam int CNT_W = 15;
  localparam int CLK_W = CNT_W + 7;
  localparam int NEXT_W = 4;

  typedef enum logic [1:0] {SEG_DUMMY = 2'd0, SEG_TX = 2'd1, SEG_RX = 2'd2} segKind_e;

  typedef struct packed {
    logic [1:0]        laneShift;
    segKind_e          kind;
    logic [CLK_W-1:0]  clocks;
    logic              last;
    logic              close;
    logic [NEXT_W-1:0] next;
    logic              bad;
  } descInfo_t;

  typedef struct packed {
    logic clkEn;
    logic segLoad;
    logic txSeg;
    logic rxSeg;
  } strobe_t;

  function automatic descInfo_t decodeDesc(input logic [31:0] d);
    descInfo_t r;
    logic [CLK_W-1:0] bits;
    logic txOn;
    logic rxOn;
    txOn = (d[3:2] == 2'b01);
    rxOn = d[6];
    r.laneShift = d[1] ? 2'd2 : (d[0] ? 2'd1 : 2'd0);
    case (d[11:10])
      2'b00:   bits = CLK_W'(d[30:16]);
      2'b01:   bits = CLK_W'(d[30:16]) << 3;
      2'b10:   bits = CLK_W'(d[30:16]) << 5;
      default: bits = CLK_W'(d[30:16]) << 7;
    endcase
    r.clocks = bits >> r.laneShift;
    r.kind   = txOn ? SEG_TX : (rxOn ? SEG_RX : SEG_DUMMY);
    r.close  = d[8];
    r.last   = d[9];
    r.next   = d[15:12];
    r.bad    = d[3] | (txOn & rxOn) | ((d[11:10] == 2'b00) & (txOn | rxOn))
             | (r.clocks == '0);
    return r;
  endfunction
endpackage

// File: rtl/qseq_datapath.sv
module qseq_datapath
  import qseq_pkg::*;
#(
  parameter int NUM_DESC = 16,
  localparam int IDX_W = $clog2(NUM_DESC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             descWe,
  input  logic [IDX_W-1:0] descAddr,
  input  logic [31:0]      descData,
  input  logic [IDX_W-1:0] rdIdx,
  output descInfo_t        info,
  input  strobe_t          stb,
  input  logic [7:0]       txData,
  input  logic [3:0]       sioIn,
  output logic [3:0]       sioOut,
  output logic [3:0]       sioOe,
  output logic [7:0]       rxData,
  output logic             needByte,
  output logic             byteEnd
);
  logic [31:0] descMem [NUM_DESC];
  descInfo_t   rawInfo;
  logic        nextOut;
  logic [1:0]  actShift;
  logic [2:0]  bitPos;
  logic [7:0]  shReg;
  logic [7:0]  cur;
  logic [7:0]  assembled;
  logic [3:0]  outBits;
  logic [3:0]  laneMask;
  logic [3:0]  nBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DESC; i++) descMem[i] <= '0;
    end else if (descWe) begin
      descMem[descAddr] <= descData;
    end
  end

  assign rawInfo = decodeDesc(descMem[rdIdx]);

  generate
    if (NUM_DESC < (1 << NEXT_W)) begin : g_rangeChk
      assign nextOut = (32'(rawInfo.next) >= NUM_DESC);
    end else begin : g_noRange
      assign nextOut = 1'b0;
    end
  endgenerate

  always_comb begin
    info     = rawInfo;
    info.bad = rawInfo.bad | nextOut;
  end

  assign nBits    = 4'd1 << actShift;
  assign needByte = (bitPos == 3'd0);
  assign byteEnd  = (({1'b0, bitPos} + nBits) == 4'd8);
  assign cur      = needByte ? txData : shReg;

  always_comb begin
    case (actShift)
      2'd0: begin
        outBits   = {3'b000, cur[7]};
        assembled = {shReg[6:0], sioIn[1]};
        laneMask  = 4'b0001;
      end
      2'd1: begin
        outBits   = {2'b00, cur[7:6]};
        assembled = {shReg[5:0], sioIn[1:0]};
        laneMask  = 4'b0011;
      end
      default: begin
        outBits   = cur[7:4];
        assembled = {shReg[3:0], sioIn[3:0]};
        laneMask  = 4'b1111;
      end
    endcase
  end

  assign sioOut = (stb.clkEn && stb.txSeg) ? outBits : 4'b0000;
  assign sioOe  = stb.txSeg ? laneMask : 4'b0000;
  assign rxData = assembled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actShift <= 2'd0;
      bitPos   <= 3'd0;
      shReg    <= 8'd0;
    end else if (stb.segLoad) begin
      actShift <= info.laneShift;
      bitPos   <= 3'd0;
      shReg    <= 8'd0;
    end else if (stb.clkEn) begin
      bitPos <= bitPos + nBits[2:0];
      shReg  <= stb.rxSeg ? assembled : (cur << nBits);
    end
  end
endmodule

// File: rtl/qseq_control.sv
module qseq_control
  import qseq_pkg::*;
#(
  parameter int NUM_DESC = 16,
  localparam int IDX_W = $clog2(NUM_DESC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] firstIdx,
  input  logic [1:0]       statusClr,
  input  descInfo_t        info,
  input  logic             needByte,
  input  logic             byteEnd,
  input  logic             txEmpty,
  input  logic             rxFull,
  output strobe_t          stb,
  output logic [IDX_W-1:0] rdIdx,
  output logic             txPop,
  output logic             rxPush,
  output logic             sclkPulse,
  output logic             csActive,
  output logic             busy,
  output logic             doneFlag,
  output logic             progErr,
  output logic [IDX_W-1:0] curIdx
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_NEXT} state_e;

  state_e           state;
  logic [IDX_W-1:0] idx;
  logic [CLK_W-1:0] clkLeft;
  segKind_e         kind;
  logic             closeR;
  logic             lastR;
  logic [IDX_W-1:0] nextR;
  logic             isTx;
  logic             isRx;
  logic             stall;
  logic             go;
  logic             finalClk;
  logic             fetch;
  logic             loadOk;
  logic             loadBad;

  assign rdIdx    = (state == S_IDLE) ? firstIdx : idx;
  assign isTx     = (state == S_RUN) && (kind == SEG_TX);
  assign isRx     = (state == S_RUN) && (kind == SEG_RX);
  assign stall    = needByte && ((isTx && txEmpty) || (isRx && rxFull));
  assign go       = (state == S_RUN) && !stall;
  assign finalClk = go && (clkLeft == CLK_W'(1));
  assign fetch    = ((state == S_IDLE) && start) || (state == S_NEXT);
  assign loadOk   = fetch && !info.bad;
  assign loadBad  = fetch && info.bad;

  assign stb.clkEn   = go;
  assign stb.segLoad = loadOk;
  assign stb.txSeg   = isTx;
  assign stb.rxSeg   = isRx;

  assign txPop     = go && isTx && needByte;
  assign rxPush    = go && isRx && byteEnd;
  assign sclkPulse = go;
  assign busy      = (state != S_IDLE);
  assign curIdx    = idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      idx      <= '0;
      clkLeft  <= '0;
      kind     <= SEG_DUMMY;
      closeR   <= 1'b0;
      lastR    <= 1'b0;
      nextR    <= '0;
      csActive <= 1'b0;
      doneFlag <= 1'b0;
      progErr  <= 1'b0;
    end else begin
      doneFlag <= (doneFlag & ~statusClr[0]) | (finalClk & lastR);
      progErr  <= (progErr & ~statusClr[1]) | loadBad;
      if ((state == S_IDLE) && start) idx <= firstIdx;
      if (loadOk) begin
        state    <= S_RUN;
        clkLeft  <= info.clocks;
        kind     <= info.kind;
        closeR   <= info.close;
        lastR    <= info.last;
        nextR    <= info.next[IDX_W-1:0];
        csActive <= 1'b1;
      end else if (loadBad) begin
        state <= S_IDLE;
        if (state == S_NEXT) csActive <= 1'b0;
      end else if (go) begin
        clkLeft <= clkLeft - CLK_W'(1);
        if (finalClk) begin
          if (closeR) csActive <= 1'b0;
          if (lastR) begin
            state <= S_IDLE;
          end else begin
            state <= S_NEXT;
            idx   <= nextR;
          end
        end
      end
    end
  end
endmodule

// File: rtl/qspi_chain_seq.sv
module qspi_chain_seq
  import qseq_pkg::*;
#(
  parameter int NUM_DESC = 16,
  localparam int IDX_W = $clog2(NUM_DESC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             descWe,
  input  logic [IDX_W-1:0] descAddr,
  input  logic [31:0]      descData,
  input  logic [IDX_W-1:0] firstIdx,
  input  logic             start,
  input  logic [1:0]       statusClr,
  input  logic [7:0]       txData,
  input  logic             txEmpty,
  output logic             txPop,
  output logic [7:0]       rxData,
  input  logic             rxFull,
  output logic             rxPush,
  output logic             sclkPulse,
  output logic [3:0]       sioOut,
  output logic [3:0]       sioOe,
  input  logic [3:0]       sioIn,
  output logic             csActive,
  output logic             busy,
  output logic             doneFlag,
  output logic             progErr,
  output logic [IDX_W-1:0] curIdx
);
  descInfo_t        info;
  strobe_t          stb;
  logic [IDX_W-1:0] rdIdx;
  logic             needByte;
  logic             byteEnd;

  qseq_datapath #(.NUM_DESC(NUM_DESC)) u_dp (
    .clk(clk), .rstN(rstN), .descWe(descWe), .descAddr(descAddr),
    .descData(descData), .rdIdx(rdIdx), .info(info), .stb(stb),
    .txData(txData), .sioIn(sioIn), .sioOut(sioOut), .sioOe(sioOe),
    .rxData(rxData), .needByte(needByte), .byteEnd(byteEnd)
  );

  qseq_control #(.NUM_DESC(NUM_DESC)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .firstIdx(firstIdx),
    .statusClr(statusClr), .info(info), .needByte(needByte),
    .byteEnd(byteEnd), .txEmpty(txEmpty), .rxFull(rxFull), .stb(stb),
    .rdIdx(rdIdx), .txPop(txPop), .rxPush(rxPush), .sclkPulse(sclkPulse),
    .csActive(csActive), .busy(busy), .doneFlag(doneFlag),
    .progErr(progErr), .curIdx(curIdx)
  );
endmodule

// File: rtl/qseq_checker.sv
module qseq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       sclkPulse,
  input logic       txPop,
  input logic       txEmpty,
  input logic       rxPush,
  input logic [3:0] sioOe,
  input logic       csActive,
  input logic       doneFlag,
  input logic       progErr,
  input logic [1:0] statusClr
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclkPulse && !txPop && !rxPush));

  a_r8_pop_has_data: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> !txEmpty);

  a_r12_clock_under_cs: assert property (@(posedge clk) disable iff (!rstN)
    sclkPulse |-> csActive);

  a_r4_rx_lines_released: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> (sioOe == 4'b0000));

  a_r3_lane_mask: assert property (@(posedge clk) disable iff (!rstN)
    (sioOe == 4'b0000) || (sioOe == 4'b0001) || (sioOe == 4'b0011) || (sioOe == 4'b1111));

  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> !busy);

  a_r10_error_stops: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progErr) |-> (!busy && !sclkPulse));

  a_r13_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !statusClr[0]) |=> doneFlag);

  a_r13_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (progErr && !statusClr[1]) |=> progErr);
endmodule

bind qspi_chain_seq qseq_checker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .sclkPulse(sclkPulse),
  .txPop(txPop), .txEmpty(txEmpty), .rxPush(rxPush), .sioOe(sioOe),
  .csActive(csActive), .doneFlag(doneFlag), .progErr(progErr),
  .statusClr(statusClr)
);

// File: tb/qspi_chain_seq_bench.sv
module qspi_chain_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        descWe = 1'b0;
  logic [3:0]  descAddr = '0;
  logic [31:0] descData = '0;
  logic [3:0]  firstIdx = '0;
  logic        start = 1'b0;
  logic [1:0]  statusClr = '0;
  logic [7:0]  txData = '0;
  logic        txEmpty = 1'b0;
  logic        rxFull = 1'b0;
  logic [3:0]  sioIn = '0;
  logic        txPop, rxPush, sclkPulse, csActive, busy, doneFlag, progErr;
  logic [7:0]  rxData;
  logic [3:0]  sioOut, sioOe, curIdx;

  qspi_chain_seq u_qspi_chain_seq (
    .clk(clk), .rstN(rstN), .descWe(descWe), .descAddr(descAddr),
    .descData(descData), .firstIdx(firstIdx), .start(start),
    .statusClr(statusClr), .txData(txData), .txEmpty(txEmpty),
    .txPop(txPop), .rxData(rxData), .rxFull(rxFull), .rxPush(rxPush),
    .sclkPulse(sclkPulse), .sioOut(sioOut), .sioOe(sioOe), .sioIn(sioIn),
    .csActive(csActive), .busy(busy), .doneFlag(doneFlag),
    .progErr(progErr), .curIdx(curIdx)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] mem [16];
  bit mRun, mGap, mCs, mDone, mErr, mClose, mLast;
  int mIdx, mNext, mClk, mKind, mN, mPos;
  logic [7:0] mSh;
  bit eGoS;
  logic [7:0] eAsmS, eCurS;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int lanes, input int txm, input int rx,
                                     input int cls, input int last, input int unit,
                                     input int nxt, input int cnt);
    logic [31:0] d;
    d = '0;
    d[1:0] = 2'(lanes); d[3:2] = 2'(txm); d[6] = rx[0]; d[8] = cls[0];
    d[9] = last[0]; d[11:10] = 2'(unit); d[15:12] = 4'(nxt); d[30:16] = 15'(cnt);
    return d;
  endfunction

  task automatic decode(input logic [31:0] d, output bit bad, output int kind,
                        output int n, output int clocks);
    int unitBits;
    int txm;
    bit rx;
    txm = int'(d[3:2]);
    rx = d[6];
    n = (d[1:0] == 2'b00) ? 1 : ((d[1:0] == 2'b01) ? 2 : 4);
    case (d[11:10])
      2'b00: unitBits = 1;
      2'b01: unitBits = 8;
      2'b10: unitBits = 32;
      default: unitBits = 128;
    endcase
    clocks = (int'(d[30:16]) * unitBits) / n;
    kind = (txm == 1) ? 1 : (rx ? 2 : 0);
    bad = (txm > 1) || (txm == 1 && rx) || (d[11:10] == 2'b00 && (txm == 1 || rx)) || (clocks == 0);
  endtask

  task automatic loadSeg(input logic [31:0] d, input int kind, input int n, input int clocks);
    mRun = 1; mGap = 0; mCs = 1; mClk = clocks; mKind = kind; mN = n;
    mClose = d[8]; mLast = d[9]; mNext = int'(d[15:12]); mPos = 0; mSh = '0;
  endtask

  // model update at the clock edge
  always @(posedge clk) begin
    bit bad, dn, er;
    int kind, n, clocks;
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mem[i] = '0;
      mRun = 0; mGap = 0; mCs = 0; mDone = 0; mErr = 0; mIdx = 0; mPos = 0; mSh = '0;
      mClk = 0; mKind = 0; mN = 1; mClose = 0; mLast = 0; mNext = 0;
    end else begin
      dn = mDone && !statusClr[0];
      er = mErr && !statusClr[1];
      if (!mRun && !mGap && start) begin
        mIdx = int'(firstIdx);
        decode(mem[mIdx], bad, kind, n, clocks);
        if (bad) er = 1; else loadSeg(mem[mIdx], kind, n, clocks);
      end else if (mGap) begin
        decode(mem[mIdx], bad, kind, n, clocks);
        if (bad) begin er = 1; mCs = 0; mGap = 0; end
        else loadSeg(mem[mIdx], kind, n, clocks);
      end else if (mRun && eGoS) begin
        mClk--;
        mSh = (mKind == 2) ? eAsmS : (eCurS << mN);
        mPos = (mPos + mN) % 8;
        if (mClk == 0) begin
          if (mClose) mCs = 0;
          mRun = 0;
          if (mLast) dn = 1;
          else begin mGap = 1; mIdx = mNext; end
        end
      end
      if (descWe) mem[descAddr] = descData;
      mDone = dn; mErr = er;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    bit eTx, eRx, eNeed, eGo, ePush;
    logic [7:0] c, asm;
    logic [3:0] eOut, eOe;
    #1;
    if (rstN && !finished) begin
      eTx = mRun && mKind == 1;
      eRx = mRun && mKind == 2;
      eNeed = (mPos == 0);
      eGo = mRun && !(eNeed && ((eTx && txEmpty) || (eRx && rxFull)));
      c = eNeed ? txData : mSh;
      case (mN)
        1: begin eOut = {3'b0, c[7]};   asm = {mSh[6:0], sioIn[1]};   eOe = 4'b0001; end
        2: begin eOut = {2'b0, c[7:6]}; asm = {mSh[5:0], sioIn[1:0]}; eOe = 4'b0011; end
        default: begin eOut = c[7:4];   asm = {mSh[3:0], sioIn[3:0]}; eOe = 4'b1111; end
      endcase
      ePush = eGo && eRx && (mPos + mN == 8);
      eGoS = eGo; eAsmS = asm; eCurS = c;
      chk("R2/R8/R9", "sclkPulse", int'(sclkPulse), int'(eGo));
      chk("R2/R8", "txPop", int'(txPop), int'(eGo && eTx && eNeed));
      chk("R2/R3", "sioOut", int'(sioOut), (eGo && eTx) ? int'(eOut) : 0);
      chk("R3/R6", "sioOe", int'(sioOe), eTx ? int'(eOe) : 0);
      chk("R4/R9", "rxPush", int'(rxPush), int'(ePush));
      if (ePush) chk("R4", "rxData", int'(rxData), int'(asm));
      chk("R12", "csActive", int'(csActive), int'(mCs));
      chk("R7", "busy", int'(busy), int'(mRun || mGap));
      chk("R7", "curIdx", int'(curIdx), mIdx);
      chk("R7/R13", "doneFlag", int'(doneFlag), int'(mDone));
      chk("R10/R11/R13", "progErr", int'(progErr), int'(mErr));
    end
  end

  // random lane and FIFO-flag stimulus
  always @(negedge clk) begin
    txData = 8'($urandom);
    sioIn = 4'($urandom);
    txEmpty = ($urandom % 4) == 0;
    rxFull = ($urandom % 4) == 0;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  task automatic wrDesc(input int idx, input logic [31:0] val);
    @(negedge clk);
    descWe = 1; descAddr = 4'(idx); descData = val;
    @(negedge clk);
    descWe = 0;
  endtask

  task automatic pulseStart(input int first);
    @(negedge clk);
    firstIdx = 4'(first); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clearFlags();
    @(negedge clk);
    statusClr = 2'b11;
    @(negedge clk);
    statusClr = 2'b00;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (4) @(negedge clk);

    // R2, R8: single-lane transmit of two bytes with close
    wrDesc(0, mk(0, 1, 0, 1, 1, 1, 0, 2));
    pulseStart(0); waitIdle();
    clearFlags();

    // R3, R4, R6, R7: chain 3 -> 7 -> 2 -> 5, restart while busy ignored (R13)
    wrDesc(3, mk(1, 1, 0, 0, 0, 2, 7, 1));
    wrDesc(7, mk(2, 0, 1, 0, 0, 1, 2, 3));
    wrDesc(2, mk(2, 0, 0, 0, 0, 0, 5, 10));
    wrDesc(5, mk(1, 0, 0, 1, 1, 1, 0, 1));
    pulseStart(3);
    repeat (5) @(negedge clk);
    firstIdx = 4'd0; start = 1;
    @(negedge clk);
    start = 0;
    waitIdle();
    clearFlags();

    // R5, R9: 16-byte unit receive and 16-byte unit quad transmit
    wrDesc(4, mk(0, 0, 1, 0, 0, 3, 9, 1));
    wrDesc(9, mk(2, 1, 0, 1, 1, 3, 0, 2));
    pulseStart(4); waitIdle();

    // R10: illegal first descriptors, flags stay set until cleared (R13)
    wrDesc(1, mk(0, 1, 1, 0, 1, 1, 0, 1));
    pulseStart(1); waitIdle();
    wrDesc(6, mk(0, 1, 0, 0, 1, 0, 0, 8));
    pulseStart(6); waitIdle();
    wrDesc(8, mk(0, 1, 0, 0, 1, 1, 0, 0));
    pulseStart(8); waitIdle();
    wrDesc(10, mk(2, 0, 0, 0, 1, 0, 0, 3));
    pulseStart(10); waitIdle();
    clearFlags();

    // R11: illegal descriptor reached through a next index drops chip select
    wrDesc(11, mk(0, 0, 0, 0, 0, 0, 12, 5));
    wrDesc(12, mk(0, 2, 0, 0, 1, 1, 0, 1));
    pulseStart(11); waitIdle();
    clearFlags();

    // R12: final segment without close holds chip select, then illegal start keeps it
    wrDesc(13, mk(1, 1, 0, 0, 1, 1, 0, 1));
    pulseStart(13); waitIdle();
    pulseStart(1); waitIdle();
    clearFlags();
    pulseStart(0); waitIdle();
    clearFlags();
    repeat (4) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule